// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a 64-bit integer core and a byte-addressed data memory whose port is one 64-bit word wide. The core hands it one access at a time: a byte address, an access size (1, 2, 4 or 8 bytes), a signed/unsigned flag, a byte-order select and, for stores, the value to write. The unit turns the access into one or two aligned word transactions on the memory port. It gathers and reorders the returned bytes, then widens the loaded value to 64 bits with zeros or with copies of its sign bit.

An access of s bytes at address A is aligned when A mod s is zero. An access that fits inside one 64-bit word, aligned or not, needs a single memory transaction. An access that runs over a word boundary is split into two transactions: the lower word goes first, then the upper word. Stores drive a per-byte write mask for each transaction. The memory port uses a request/ready handshake and returns read data exactly one cycle after a read is accepted. While a sequence is in progress, `busy` is high and new requests are not taken.

Top module: `ldst_align_unit`

## Requirements
- R1: Every memory transaction carries a word-aligned address (`mem_addr[2:0]` is 0). For an aligned access it is the single transaction, at the address with its low three bits cleared.
- R2: An access whose offset within its word plus its size exceeds 8 bytes issues exactly two transactions: first at the containing word's address, then at that address plus 8. `done` rises only after both have completed.
- R3: An access whose offset plus size is at most 8 bytes issues exactly one transaction, even when it is misaligned.
- R4: With `req_big_endian`=0, value byte k (k=0 least significant) maps to address A+k.
- R5: With `req_big_endian`=1, value byte k maps to address A+s-1-k, where s is the size in bytes.
- R6: `req_size` encodes 0=byte, 1=half (2 bytes), 2=word (4 bytes), 3=double (8 bytes). With `req_signed`=0, a byte, half or word load returns zeros above the loaded bytes.
- R7: With `req_signed`=1, a byte, half or word load fills the bits above the loaded bytes with the loaded value's most significant bit.
- R8: For a store, `mem_be` bit i of each transaction is 1 exactly when byte lane i of that word is written, and `mem_wdata` holds the value byte bound for that lane. Bytes outside the access keep their contents.
- R9: `busy` is 1 from the cycle after acceptance until the sequence ends. A request presented while `busy` is 1 is ignored: it issues no transaction and changes no memory.
- R10: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R11: After reset, `busy`, `done` and `mem_req` are 0. `done` is a one-cycle pulse, and `load_data` holds the load result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_signed | input | 1 | Sign-fill the load result |
| req_big_endian | input | 1 | Byte order select, 1 = big-endian |
| req_wdata | input | 64 | Store value, right-justified |
| busy | output | 1 | Sequence in progress, requests ignored |
| done | output | 1 | Access finished (one-cycle pulse) |
| load_data | output | 64 | Widened load result, valid with done |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | 8 | Per-lane byte mask |
| mem_wdata | output | 64 | Write data, lane-arranged |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid (one cycle after acceptance) |
| mem_rdata | input | 64 | Read data, lane i = address base+i |

## Verification
The hardest case to reach from the ports is a new request that arrives in the middle of a word-crossing sequence while the memory is stalling. The bench starts a crossing load and drives a competing store in the cycle where `busy` has just risen. It then confirms that only two transactions occurred and that the competing store's target bytes are unchanged. A second pass repeats crossing loads and stores with `mem_ready` dropped on every other cycle, so both halves of a split access wait for the memory. A monitor checks that the request fields hold steady across each stall.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int LANES     = 8;
  localparam int WORD_BITS = LANES * 8;
  localparam int OFS_W     = $clog2(LANES);
  localparam int WIN_LANES = 2 * LANES;
  localparam int WIN_BITS  = WIN_LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_LO_WAIT,
    ST_HI,
    ST_HI_WAIT,
    ST_FIN
  } seq_state_e;

  // number of bytes moved by an access of the given size
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // lane inside the two-word window that holds value byte k
  function automatic logic [3:0] value_lane(input logic [2:0] k,
                                            input logic [2:0] ofs,
                                            input logic [3:0] nb,
                                            input logic       big);
    logic [4:0] t;
    if (big) t = {2'b00, ofs} + {1'b0, nb} - 5'd1 - {2'b00, k};
    else     t = {2'b00, ofs} + {2'b00, k};
    return t[3:0];
  endfunction

  // true when the access runs past the end of its word
  function automatic logic crosses_word(input logic [2:0] ofs,
                                        input logic [3:0] nb);
    return ({1'b0, ofs} + nb) > 4'd8;
  endfunction

  // widen a right-justified raw value to 64 bits
  function automatic logic [63:0] widen(input logic [63:0] raw,
                                        input logic [1:0]  sz,
                                        input logic        sgn);
    logic [63:0] r;
    case (acc_size_e'(sz))
      SZ_BYTE: r = {{56{sgn & raw[7]}},  raw[7:0]};
      SZ_HALF: r = {{48{sgn & raw[15]}}, raw[15:0]};
      SZ_WORD: r = {{32{sgn & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ldst_store_pack.sv
module ldst_store_pack
  import ldst_pkg::*;
(
  input  logic [OFS_W-1:0]     ofs,
  input  logic [1:0]           size,
  input  logic                 big,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [WIN_LANES-1:0] mask_win,
  output logic [WIN_BITS-1:0]  data_win
);

  logic [3:0] nb;
  assign nb = size_bytes(size);

  always_comb begin
    mask_win = '0;
    data_win = '0;
    for (int k = 0; k < LANES; k++) begin
      if (4'(k) < nb) begin
        mask_win[value_lane(3'(k), ofs, nb, big)] = 1'b1;
        data_win[{value_lane(3'(k), ofs, nb, big), 3'b000} +: 8] = wdata[k*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/ldst_load_merge.sv
module ldst_load_merge
  import ldst_pkg::*;
(
  input  logic [WORD_BITS-1:0] lo_word,
  input  logic [WORD_BITS-1:0] hi_word,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [1:0]           size,
  input  logic                 big,
  input  logic                 sgn,
  output logic [WORD_BITS-1:0] result
);

  logic [WIN_BITS-1:0]  window;
  logic [WORD_BITS-1:0] raw;
  logic [3:0]           nb;

  assign window = {hi_word, lo_word};
  assign nb     = size_bytes(size);

  always_comb begin
    raw = '0;
    for (int k = 0; k < LANES; k++) begin
      if (4'(k) < nb)
        raw[k*8 +: 8] = window[{value_lane(3'(k), ofs, nb, big), 3'b000} +: 8];
    end
  end

  assign result = widen(raw, size, sgn);

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_store,
  input  logic crosses,
  input  logic mem_ready,
  input  logic mem_rvalid,
  output logic busy,
  output logic done,
  output logic phase_lo,
  output logic phase_hi,
  output logic cap_lo,
  output logic cap_hi
);

  seq_state_e st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE, ST_FIN: nxt = accept ? ST_LO : ST_IDLE;
      ST_LO: if (mem_ready)
               nxt = is_store ? (crosses ? ST_HI : ST_FIN) : ST_LO_WAIT;
      ST_LO_WAIT: if (mem_rvalid) nxt = crosses ? ST_HI : ST_FIN;
      ST_HI: if (mem_ready) nxt = is_store ? ST_FIN : ST_HI_WAIT;
      ST_HI_WAIT: if (mem_rvalid) nxt = ST_FIN;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign busy     = (st != ST_IDLE) && (st != ST_FIN);
  assign done     = (st == ST_FIN);
  assign phase_lo = (st == ST_LO);
  assign phase_hi = (st == ST_HI);
  assign cap_lo   = (st == ST_LO_WAIT) && mem_rvalid;
  assign cap_hi   = (st == ST_HI_WAIT) && mem_rvalid;

endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_signed,
  input  logic                 req_big_endian,
  input  logic [WORD_BITS-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_BITS-1:0] load_data,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [LANES-1:0]     mem_be,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic                 mem_ready,
  input  logic                 mem_rvalid,
  input  logic [WORD_BITS-1:0] mem_rdata
);

  localparam logic [AW-1:0] WORD_STEP = AW'(LANES);

  // captured request
  logic                 op_store, op_signed, op_big;
  logic [AW-1:0]        op_addr;
  logic [1:0]           op_size;
  logic [WORD_BITS-1:0] op_wdata;
  logic [WORD_BITS-1:0] lo_q, hi_q;

  // named internal events
  logic                 accept;
  logic                 phase_lo, phase_hi, cap_lo, cap_hi;
  logic [OFS_W-1:0]     op_ofs;
  logic [AW-1:0]        op_base;
  logic                 op_cross;
  logic [WIN_LANES-1:0] mask_win;
  logic [WIN_BITS-1:0]  data_win;

  assign accept   = req_valid && !busy;
  assign op_ofs   = op_addr[OFS_W-1:0];
  assign op_base  = {op_addr[AW-1:OFS_W], {OFS_W{1'b0}}};
  assign op_cross = crosses_word(op_ofs, size_bytes(op_size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_store  <= 1'b0;
      op_signed <= 1'b0;
      op_big    <= 1'b0;
      op_addr   <= '0;
      op_size   <= 2'd0;
      op_wdata  <= '0;
    end else if (accept) begin
      op_store  <= req_store;
      op_signed <= req_signed;
      op_big    <= req_big_endian;
      op_addr   <= req_addr;
      op_size   <= req_size;
      op_wdata  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (accept) hi_q <= '0;
      if (cap_lo) lo_q <= mem_rdata;
      if (cap_hi) hi_q <= mem_rdata;
    end
  end

  ldst_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .is_store   (op_store),
    .crosses    (op_cross),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .done       (done),
    .phase_lo   (phase_lo),
    .phase_hi   (phase_hi),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi)
  );

  ldst_store_pack u_pack (
    .ofs      (op_ofs),
    .size     (op_size),
    .big      (op_big),
    .wdata    (op_wdata),
    .mask_win (mask_win),
    .data_win (data_win)
  );

  ldst_load_merge u_merge (
    .lo_word (lo_q),
    .hi_word (hi_q),
    .ofs     (op_ofs),
    .size    (op_size),
    .big     (op_big),
    .sgn     (op_signed),
    .result  (load_data)
  );

  assign mem_req   = phase_lo || phase_hi;
  assign mem_we    = mem_req && op_store;
  assign mem_addr  = phase_hi ? (op_base + WORD_STEP) : op_base;
  assign mem_be    = phase_hi ? mask_win[WIN_LANES-1:LANES] : mask_win[LANES-1:0];
  assign mem_wdata = phase_hi ? data_win[WIN_BITS-1:WORD_BITS] : data_win[WORD_BITS-1:0];

endmodule

// File: rtl/ldst_align_checker.sv
module ldst_align_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [63:0]   load_data,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_be,
  input logic          mem_ready,
  input logic          phase_hi,
  input logic [AW-1:0] op_base,
  input logic          op_cross,
  input logic          op_store,
  input logic          op_signed,
  input logic [1:0]    op_size
);

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'd0));

  p_upper_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && phase_hi) |-> (mem_addr == op_base + AW'(8)));

  p_one_txn_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |-> op_cross);

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_store && !op_signed && op_size == 2'd0) |-> (load_data[63:8] == 56'd0));

  p_store_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 8'd0));

  p_no_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind ldst_align_unit ldst_align_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .load_data (load_data),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_ready (mem_ready),
  .phase_hi  (phase_hi),
  .op_base   (op_base),
  .op_cross  (op_cross),
  .op_store  (op_store),
  .op_signed (op_signed),
  .op_size   (op_size)
);

// File: tb/test_ldst_align_unit.sv
module test_ldst_align_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_big_endian = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, done, mem_req, mem_we;
  logic [63:0] load_data, mem_wdata;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic        mem_ready, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_align_unit #(.AW(AW)) i_ldst_align_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
    .req_big_endian(req_big_endian), .req_wdata(req_wdata), .busy(busy),
    .done(done), .load_data(load_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  // ---------------- memory model ----------------
  logic [7:0]  mem  [0:511];
  logic [7:0]  bref [0:511];
  logic        stall_mode = 1'b0, rdy_tog = 1'b0;
  int          tx_count = 0;
  logic [31:0] tx_addr_log [0:7];
  logic [7:0]  tx_be_log   [0:7];

  assign mem_ready = !stall_mode || rdy_tog;

  always @(posedge clk) begin
    logic [63:0] w;
    rdy_tog    <= ~rdy_tog;
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_ready) begin
      tx_addr_log[tx_count % 8] <= mem_addr;
      tx_be_log[tx_count % 8]   <= mem_be;
      tx_count <= tx_count + 1;
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[{mem_addr[8:3], 3'(b)}] <= mem_wdata[b*8 +: 8];
      end else begin
        for (int b = 0; b < 8; b++) w[b*8 +: 8] = mem[{mem_addr[8:3], 3'(b)}];
        mem_rvalid <= 1'b1;
        mem_rdata  <= w;
      end
    end
  end

  // stall hold monitor (R10)
  int          hold_err = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic [7:0]  prev_be;
  logic [63:0] prev_wd;
  always @(negedge clk) begin
    if (prev_stall && !(mem_req && mem_addr == prev_addr && mem_be == prev_be && mem_wdata == prev_wd))
      hold_err++;
    prev_stall = rst_n && mem_req && !mem_ready;
    prev_addr  = mem_addr;
    prev_be    = mem_be;
    prev_wd    = mem_wdata;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(int a, logic [1:0] sz, logic sg, logic bg);
    int nb = 1 << sz;
    logic [63:0] v = '0;
    for (int k = 0; k < nb; k++) v[k*8 +: 8] = bref[bg ? a + nb - 1 - k : a + k];
    if (sg && nb < 8 && v[nb*8-1])
      for (int j = nb*8; j < 64; j++) v[j] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_be(int a, logic [1:0] sz, int word_sel);
    int nb = 1 << sz;
    logic [7:0] m = '0;
    for (int k = 0; k < nb; k++)
      if (((a + k) >> 3) == ((a >> 3) + word_sel)) m[(a + k) % 8] = 1'b1;
    return m;
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R11 done never rose", 64'd0, 64'd1);
  endtask

  task automatic run_op(input logic st, input int a, input logic [1:0] sz, input logic sg,
                        input logic bg, input logic [63:0] wd,
                        output logic [63:0] res, output int ntx, output int first);
    int nb = 1 << sz;
    first = tx_count;
    @(negedge clk);
    req_store = st; req_addr = 32'(a); req_size = sz; req_signed = sg;
    req_big_endian = bg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    res = load_data;
    ntx = tx_count - first;
    if (st)
      for (int k = 0; k < nb; k++) bref[bg ? a + nb - 1 - k : a + k] = wd[k*8 +: 8];
  endtask

  task automatic load_check(input string tag, input int a, input logic [1:0] sz,
                            input logic sg, input logic bg, input int exp_ntx);
    logic [63:0] r, e;
    int nt, f;
    e = exp_load(a, sz, sg, bg);
    run_op(1'b0, a, sz, sg, bg, 64'd0, r, nt, f);
    chk(r == e, tag, r, e);
    chk(nt == exp_ntx, {tag, " txn count"}, 64'(nt), 64'(exp_ntx));
    chk(tx_addr_log[f % 8] == 32'(a & ~7), {tag, " first addr"}, 64'(tx_addr_log[f % 8]), 64'(a & ~7));
    if (exp_ntx == 2)
      chk(tx_addr_log[(f + 1) % 8] == 32'((a & ~7) + 8), {tag, " second addr"},
          64'(tx_addr_log[(f + 1) % 8]), 64'((a & ~7) + 8));
  endtask

  task automatic store_check(input string tag, input int a, input logic [1:0] sz,
                             input logic bg, input logic [63:0] wd, input int exp_ntx);
    logic [63:0] r;
    int nt, f;
    run_op(1'b1, a, sz, 1'b0, bg, wd, r, nt, f);
    chk(nt == exp_ntx, {tag, " txn count"}, 64'(nt), 64'(exp_ntx));
    chk(tx_be_log[f % 8] == exp_be(a, sz, 0), {tag, " lower mask"}, 64'(tx_be_log[f % 8]), 64'(exp_be(a, sz, 0)));
    if (exp_ntx == 2)
      chk(tx_be_log[(f + 1) % 8] == exp_be(a, sz, 1), {tag, " upper mask"},
          64'(tx_be_log[(f + 1) % 8]), 64'(exp_be(a, sz, 1)));
    // whole neighbourhood must match the reference image
    for (int w = (a >> 3) - 1; w <= (a >> 3) + 2; w++)
      for (int b = 0; b < 8; b++)
        if (mem[w*8 + b] !== bref[w*8 + b])
          chk(1'b0, {tag, " memory image"}, 64'(mem[w*8 + b]), 64'(bref[w*8 + b]));
    n_checks++;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R11 done after reset", 64'(done), 64'd0);
    chk(mem_req == 1'b0, "R11 mem_req after reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_aligned();
    load_check("R1 R4 aligned byte LE",   32'h21, 2'd0, 1'b0, 1'b0, 1);
    load_check("R1 R4 aligned half LE",   32'h32, 2'd1, 1'b0, 1'b0, 1);
    load_check("R1 R4 aligned word LE",   32'h44, 2'd2, 1'b0, 1'b0, 1);
    load_check("R1 R4 aligned double LE", 32'h58, 2'd3, 1'b0, 1'b0, 1);
  endtask

  task automatic t_big_endian();
    load_check("R5 aligned word BE",   32'h64, 2'd2, 1'b0, 1'b1, 1);
    load_check("R5 aligned double BE", 32'h70, 2'd3, 1'b0, 1'b1, 1);
    load_check("R5 misaligned half BE", 32'h7B, 2'd1, 1'b0, 1'b1, 1);
  endtask

  task automatic t_within_word();
    load_check("R3 half at offset 1",   32'h81, 2'd1, 1'b0, 1'b0, 1);
    load_check("R3 word at offset 3",   32'h8B, 2'd2, 1'b0, 1'b0, 1);
    load_check("R3 half at offset 6",   32'h96, 2'd1, 1'b0, 1'b1, 1);
  endtask

  task automatic t_cross();
    load_check("R2 word at offset 6 LE",   32'hA6, 2'd2, 1'b0, 1'b0, 2);
    load_check("R2 double at offset 5 LE", 32'hB5, 2'd3, 1'b0, 1'b0, 2);
    load_check("R2 double at offset 3 BE", 32'hC3, 2'd3, 1'b0, 1'b1, 2);
    load_check("R2 half at offset 7 BE",   32'hCF, 2'd1, 1'b0, 1'b1, 2);
    @(negedge clk);
    chk(done == 1'b0, "R11 done lasts one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_extend();
    logic [63:0] r; int nt, f;
    run_op(1'b1, 32'h100, 2'd0, 1'b0, 1'b0, 64'h9C, r, nt, f);
    load_check("R7 signed byte negative",   32'h100, 2'd0, 1'b1, 1'b0, 1);
    load_check("R6 unsigned byte",          32'h100, 2'd0, 1'b0, 1'b0, 1);
    run_op(1'b1, 32'h10E, 2'd2, 1'b0, 1'b0, 64'hF123_4567, r, nt, f);
    load_check("R7 signed crossing word",   32'h10E, 2'd2, 1'b1, 1'b0, 2);
    load_check("R6 unsigned crossing word", 32'h10E, 2'd2, 1'b0, 1'b0, 2);
    run_op(1'b1, 32'h120, 2'd1, 1'b0, 1'b1, 64'h8001, r, nt, f);
    load_check("R7 signed half BE",   32'h120, 2'd1, 1'b1, 1'b1, 1);
    load_check("R6 unsigned half BE", 32'h120, 2'd1, 1'b0, 1'b1, 1);
    run_op(1'b1, 32'h128, 2'd1, 1'b0, 1'b0, 64'h7FFE, r, nt, f);
    load_check("R7 signed half positive", 32'h128, 2'd1, 1'b1, 1'b0, 1);
  endtask

  task automatic t_store();
    store_check("R8 byte store",               32'h143, 2'd0, 1'b0, 64'hA5, 1);
    store_check("R8 crossing word store LE",   32'h14D, 2'd2, 1'b0, 64'h1122_3344, 2);
    store_check("R8 crossing double store BE", 32'h15A, 2'd3, 1'b1, 64'h0102_0304_0506_0708, 2);
    store_check("R8 aligned double store",     32'h168, 2'd3, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1);
    load_check("R8 read back crossing BE", 32'h15A, 2'd3, 1'b0, 1'b1, 2);
  endtask

  task automatic t_busy();
    logic [63:0] e, r;
    int c0;
    e  = exp_load(32'h1A5, 2'd3, 1'b0, 1'b0);
    c0 = tx_count;
    @(negedge clk);
    req_store = 1'b0; req_addr = 32'h1A5; req_size = 2'd3; req_signed = 1'b0;
    req_big_endian = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy during sequence", 64'(busy), 64'd1);
    req_store = 1'b1; req_addr = 32'h1C0; req_size = 2'd3; req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    r = load_data;
    chk(r == e, "R9 load result with intruder", r, e);
    repeat (4) @(negedge clk);
    chk(tx_count - c0 == 2, "R9 intruder issued no transaction", 64'(tx_count - c0), 64'd2);
    chk(busy == 1'b0, "R9 busy clear after done", 64'(busy), 64'd0);
    load_check("R9 intruder target unchanged", 32'h1C0, 2'd3, 1'b0, 1'b0, 1);
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    hold_err = 0;
    load_check("R10 stalled crossing load", 32'h1D6, 2'd2, 1'b1, 1'b1, 2);
    store_check("R10 stalled crossing store", 32'h1E3, 2'd3, 1'b0, 64'hCAFE_F00D_1234_5678, 2);
    load_check("R10 stalled read back", 32'h1E3, 2'd3, 1'b0, 1'b0, 2);
    chk(hold_err == 0, "R10 fields held during stall", 64'(hold_err), 64'd0);
    stall_mode = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]  = 8'(i * 37 + 5);
      bref[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_big_endian();
    t_within_word();
    t_cross();
    t_extend();
    t_store();
    t_busy();
    t_stall();
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule